// File: doc/BRIEF.md
# Staggered Beacon Interval Timer

This block keeps a free-running 64-bit timestamp in microseconds and derives a time-unit count from it (one unit = 1024 µs, the timestamp shifted right by ten). Once programmed with a first target time and a beacon period, it raises a one-clock alert strobe each time the time-unit count reaches the target. It then moves the target forward by one programmed interval.

For several interfaces beaconing from one radio, staggered mode splits the beacon period into N equal slots and raises one alert per slot. With each alert the block reports the slot the timestamp currently falls in and the slot whose owner must prepare the next beacon. The block also tracks whether the beacon queue was still busy at each alert. It counts consecutive misses, raises a stuck alarm at a programmable threshold, and pulses an issue strobe when a beacon may go out. Programming either zeroes the timestamp, when the first target equals the effective interval, or walks the target forward in whole intervals until it lies at least two units ahead of the present time. The target and interval are also presented in eighths of a time unit for a finer-grained timer.

Top module: `bcn_stagger_timer`

## Requirements
- R1: The timestamp `tsf_o` increments by one on each clock with `us_tick_i` high, and holds its value when `us_tick_i` is low. The time-unit count is `tsf_o >> 10`.
- R2: A load with the timer enabled and `cfg_next_tbtt_i` equal to the effective interval zeroes the timestamp and sets `tsf_rst_o`. The first alert then comes at time unit `cfg_next_tbtt_i`.
- R3: A load that does not reset the timestamp keeps it counting and clears `tsf_rst_o`. The first alert comes at the smallest `next + k*interval` (k ≥ 0) that is not below the time-unit count at the load plus 2.
- R4: `swba_o` is high for exactly one clock per alert. Successive alerts are one effective interval apart in time units.
- R5: The effective interval is the masked beacon period when `cfg_stagger_i` is 0. When `cfg_stagger_i` is 1 it is that period divided (integer) by N = `cfg_nslot_i`, with N = 0 treated as 1. The slot count field is ignored when staggering is off.
- R6: With each alert, `slot_o` = ((tu mod P) × N) / P and `owner_o` = (slot + 1) mod N. Here tu is the time-unit count at the alert, P is the masked beacon period, and N is the slot count in effect (1 when not staggered, so both read 0).
- R7: At an alert with `q_pending_i` high, `miss_cnt_o` increments (saturating at 15) and `beacon_issue_o` stays low. At an alert with `q_pending_i` low, `miss_cnt_o` clears and `beacon_issue_o` pulses with `swba_o`. Between alerts the counter holds.
- R8: `stuck_o` is high whenever `miss_thresh_i` is nonzero and `miss_cnt_o` ≥ `miss_thresh_i`.
- R9: Only the low 16 bits of `cfg_intval_i` are used. A load with an effective interval of 0 or with `cfg_enable_i` low stops alerts, clears `run_o`, and leaves the timestamp untouched.
- R10: `tbtt_x8_o` equals the current target × 8 and `ivl_x8_o` equals the effective interval × 8. `run_o` and `tsf_rst_o` carry the enable and timestamp-reset state.
- R11: A load in the same clock as an alert detection takes priority. No alert, slot update or miss update happens for that detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-microsecond tick enable |
| cfg_load_i | input | 1 | Program strobe for the cfg_* fields |
| cfg_enable_i | input | 1 | Timer enable applied on load |
| cfg_stagger_i | input | 1 | Staggered slot mode |
| cfg_nslot_i | input | 3 | Slot count N (0 means 1) |
| cfg_next_tbtt_i | input | 32 | First target time in time units |
| cfg_intval_i | input | 32 | Beacon period in time units; low 16 bits used |
| q_pending_i | input | 1 | Beacon queue still holds a frame |
| miss_thresh_i | input | 4 | Consecutive-miss alarm threshold (0 = off) |
| tsf_o | output | 64 | Microsecond timestamp |
| swba_o | output | 1 | One-clock beacon alert strobe |
| beacon_issue_o | output | 1 | Alert found the queue empty; beacon may go |
| slot_o | output | 3 | Current slot at the last alert |
| owner_o | output | 3 | Slot whose beacon is prepared at the last alert |
| miss_cnt_o | output | 4 | Consecutive missed beacons |
| stuck_o | output | 1 | Miss count at or over threshold |
| run_o | output | 1 | Timer armed |
| tsf_rst_o | output | 1 | Last load zeroed the timestamp |
| tbtt_x8_o | output | 35 | Current target in eighths of a time unit |
| ivl_x8_o | output | 19 | Effective interval in eighths of a time unit |

## Verification
Reprogramming and alert detection can land in the same clock: the comparator sees the time-unit count reach the target while a new load is applied. The bench watches the timestamp until it equals target × 1024, the exact cycle in which detection is live, and drives a disabling load into that clock with the queue marked busy. It judges the outcome from the ports. No alert strobe may follow, `run_o` must drop, and the miss counter must stay at zero, where a leaked alert would have moved it to one.

// File: rtl/bcn_timer_pkg.sv
package bcn_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_RUN   = 2'd2
  } sched_st_e;
endpackage

// File: rtl/bcn_tsf_ctr.sv
module bcn_tsf_ctr #(
  parameter int TSF_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [TSF_W-1:0] tsf_o
);
  logic [TSF_W-1:0] tsf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tsf_q <= '0;
    else if (clr_i)  tsf_q <= '0;
    else if (tick_i) tsf_q <= tsf_q + TSF_W'(1);
  end

  assign tsf_o = tsf_q;

  // R1: no tick, no clear -> timestamp frozen
  a_r1_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(tsf_q));
endmodule

// File: rtl/bcn_tbtt_sched.sv
module bcn_tbtt_sched
  import bcn_timer_pkg::*;
#(
  parameter int TU_W     = 32,
  parameter int PERIOD_W = 16,
  parameter int SLOT_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TU_W-1:0]     tu_i,
  input  logic                load_i,
  input  logic                enable_i,
  input  logic                stagger_i,
  input  logic [SLOT_W-1:0]   nslot_i,
  input  logic [TU_W-1:0]     next_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                alert_o,
  output logic                swba_o,
  output logic                clr_tsf_o,
  output logic [TU_W-1:0]     target_o,
  output logic [PERIOD_W-1:0] ivl_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [SLOT_W-1:0]   nslot_o,
  output logic                run_o,
  output logic                tsf_rst_o
);
  sched_st_e           st_q;
  logic [TU_W-1:0]     target_q, floor_q;
  logic [PERIOD_W-1:0] ivl_q, period_q;
  logic [SLOT_W-1:0]   n_q;
  logic                swba_q, tsf_rst_q;

  logic [SLOT_W-1:0]   n_eff;
  logic [PERIOD_W-1:0] ivl_new;
  logic                go, rst_cond;

  always_comb begin
    n_eff    = (stagger_i && nslot_i != '0) ? nslot_i : SLOT_W'(1);
    ivl_new  = period_i / PERIOD_W'(n_eff);
    go       = enable_i && (ivl_new != '0);
    rst_cond = go && (next_i == TU_W'(ivl_new));
  end

  assign clr_tsf_o = load_i && rst_cond;
  // load wins over a coincident detection
  assign alert_o   = !load_i && (st_q == ST_RUN) && (tu_i >= target_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      target_q  <= '0;
      floor_q   <= '0;
      ivl_q     <= '0;
      period_q  <= '0;
      n_q       <= SLOT_W'(1);
      swba_q    <= 1'b0;
      tsf_rst_q <= 1'b0;
    end else begin
      swba_q <= alert_o;
      if (load_i) begin
        ivl_q     <= ivl_new;
        period_q  <= period_i;
        n_q       <= n_eff;
        target_q  <= next_i;
        tsf_rst_q <= rst_cond;
        if (!go) begin
          st_q    <= ST_IDLE;
          floor_q <= '0;
        end else if (rst_cond) begin
          st_q    <= ST_RUN;
          floor_q <= '0;
        end else begin
          st_q    <= ST_ALIGN;
          floor_q <= tu_i + TU_W'(2);
        end
      end else begin
        unique case (st_q)
          ST_ALIGN: begin
            if (target_q < floor_q) target_q <= target_q + TU_W'(ivl_q);
            else                    st_q     <= ST_RUN;
          end
          ST_RUN: if (alert_o) target_q <= target_q + TU_W'(ivl_q);
          default: ;
        endcase
      end
    end
  end

  assign swba_o    = swba_q;
  assign target_o  = target_q;
  assign ivl_o     = ivl_q;
  assign period_o  = period_q;
  assign nslot_o   = n_q;
  assign run_o     = (st_q != ST_IDLE);
  assign tsf_rst_o = tsf_rst_q;

  // R4: strobe never lasts two clocks
  a_r4_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swba_q |=> !swba_q);
  // R9: no alert unless the schedule is running
  a_r9_no_alert_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN) |=> !swba_q);
  // R3: a running target is never behind the alignment floor
  a_r3_target_ahead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> (target_q >= floor_q));
  // R5: armed schedule always has a nonzero interval
  a_r5_ivl_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (ivl_q != '0));
endmodule

// File: rtl/bcn_slot_sel.sv
module bcn_slot_sel #(
  parameter int TU_W     = 32,
  parameter int PERIOD_W = 16,
  parameter int SLOT_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alert_i,
  input  logic [TU_W-1:0]     tu_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [SLOT_W-1:0]   n_i,
  output logic [SLOT_W-1:0]   slot_o,
  output logic [SLOT_W-1:0]   owner_o
);
  localparam int EXT_W = TU_W + SLOT_W;

  logic [EXT_W-1:0]  p_ext, n_ext, tu_ext;
  logic [SLOT_W-1:0] slot_c, owner_c, slot_q, owner_q;

  always_comb begin
    p_ext  = EXT_W'(period_i);
    n_ext  = EXT_W'(n_i);
    tu_ext = EXT_W'(tu_i);
    if (period_i == '0) slot_c = '0;
    else                slot_c = SLOT_W'(((tu_ext % p_ext) * n_ext) / p_ext);
    owner_c = (EXT_W'(slot_c) + EXT_W'(1) >= n_ext) ? '0 : slot_c + SLOT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      owner_q <= '0;
    end else if (alert_i) begin
      slot_q  <= slot_c;
      owner_q <= owner_c;
    end
  end

  assign slot_o  = slot_q;
  assign owner_o = owner_q;

  // R6: reported slots stay inside the slot count
  a_r6_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_i && n_i != '0) |=> (slot_q < $past(n_i)) && (owner_q < $past(n_i)));
  // R6: slot report only moves on an alert
  a_r6_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alert_i |=> ($stable(slot_q) && $stable(owner_q)));
endmodule

// File: rtl/bcn_miss_track.sv
module bcn_miss_track #(
  parameter int MISS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alert_i,
  input  logic              pending_i,
  input  logic [MISS_W-1:0] thresh_i,
  output logic [MISS_W-1:0] miss_o,
  output logic              issue_o,
  output logic              stuck_o
);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic [MISS_W-1:0] miss_q;
  logic              issue_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q  <= '0;
      issue_q <= 1'b0;
    end else begin
      issue_q <= alert_i && !pending_i;
      if (alert_i) begin
        if (!pending_i)              miss_q <= '0;
        else if (miss_q != MISS_MAX) miss_q <= miss_q + MISS_W'(1);
      end
    end
  end

  assign miss_o  = miss_q;
  assign issue_o = issue_q;
  assign stuck_o = (thresh_i != '0) && (miss_q >= thresh_i);

  // R7: counter moves only at alerts
  a_r7_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alert_i |=> $stable(miss_q));
  // R7: busy queue never yields an issue strobe
  a_r7_no_issue_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_i && pending_i) |=> !issue_q);
endmodule

// File: rtl/bcn_stagger_timer.sv
module bcn_stagger_timer #(
  parameter int TSF_W    = 64,
  parameter int TU_W     = 32,
  parameter int IVL_IN_W = 32,
  parameter int PERIOD_W = 16,
  parameter int SLOT_W   = 3,
  parameter int MISS_W   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  us_tick_i,
  input  logic                  cfg_load_i,
  input  logic                  cfg_enable_i,
  input  logic                  cfg_stagger_i,
  input  logic [SLOT_W-1:0]     cfg_nslot_i,
  input  logic [TU_W-1:0]       cfg_next_tbtt_i,
  input  logic [IVL_IN_W-1:0]   cfg_intval_i,
  input  logic                  q_pending_i,
  input  logic [MISS_W-1:0]     miss_thresh_i,
  output logic [TSF_W-1:0]      tsf_o,
  output logic                  swba_o,
  output logic                  beacon_issue_o,
  output logic [SLOT_W-1:0]     slot_o,
  output logic [SLOT_W-1:0]     owner_o,
  output logic [MISS_W-1:0]     miss_cnt_o,
  output logic                  stuck_o,
  output logic                  run_o,
  output logic                  tsf_rst_o,
  output logic [TU_W+2:0]       tbtt_x8_o,
  output logic [PERIOD_W+2:0]   ivl_x8_o
);
  localparam int TU_SHIFT = 10;

  logic [TSF_W-1:0]    tsf;
  logic [TU_W-1:0]     tu, target;
  logic [PERIOD_W-1:0] period_in, ivl, period_run;
  logic [SLOT_W-1:0]   n_run;
  logic                alert, clr_tsf;
  logic                unused_hi;

  assign tu        = tsf[TU_SHIFT +: TU_W];
  assign period_in = cfg_intval_i[PERIOD_W-1:0];
  assign unused_hi = ^cfg_intval_i[IVL_IN_W-1:PERIOD_W];

  bcn_tsf_ctr #(.TSF_W(TSF_W)) u_tsf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (us_tick_i),
    .clr_i  (clr_tsf),
    .tsf_o  (tsf)
  );

  bcn_tbtt_sched #(.TU_W(TU_W), .PERIOD_W(PERIOD_W), .SLOT_W(SLOT_W)) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tu_i      (tu),
    .load_i    (cfg_load_i),
    .enable_i  (cfg_enable_i),
    .stagger_i (cfg_stagger_i),
    .nslot_i   (cfg_nslot_i),
    .next_i    (cfg_next_tbtt_i),
    .period_i  (period_in),
    .alert_o   (alert),
    .swba_o    (swba_o),
    .clr_tsf_o (clr_tsf),
    .target_o  (target),
    .ivl_o     (ivl),
    .period_o  (period_run),
    .nslot_o   (n_run),
    .run_o     (run_o),
    .tsf_rst_o (tsf_rst_o)
  );

  bcn_slot_sel #(.TU_W(TU_W), .PERIOD_W(PERIOD_W), .SLOT_W(SLOT_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alert_i  (alert),
    .tu_i     (tu),
    .period_i (period_run),
    .n_i      (n_run),
    .slot_o   (slot_o),
    .owner_o  (owner_o)
  );

  bcn_miss_track #(.MISS_W(MISS_W)) u_miss (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alert_i   (alert),
    .pending_i (q_pending_i),
    .thresh_i  (miss_thresh_i),
    .miss_o    (miss_cnt_o),
    .issue_o   (beacon_issue_o),
    .stuck_o   (stuck_o)
  );

  assign tsf_o     = tsf;
  assign tbtt_x8_o = {target, 3'b000};
  assign ivl_x8_o  = {ivl, 3'b000};
endmodule

// File: tb/bcn_stagger_timer_tb_top.sv
module bcn_stagger_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, load = 1'b0, en = 1'b0, stg = 1'b0, pend = 1'b0;
  logic [2:0]  nslot = '0;
  logic [31:0] nxt = '0, ivl = '0;
  logic [3:0]  thr = '0;
  logic [63:0] tsf;
  logic        swba, issue, stuck, run, trst;
  logic [2:0]  slot, owner;
  logic [3:0]  miss;
  logic [34:0] tbtt8;
  logic [18:0] ivl8;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2:0]  s_slot, s_owner;
  logic [3:0]  s_miss;
  logic        s_issue, s_stuck;
  logic [34:0] s_tbtt;

  always #5 clk = ~clk;

  bcn_stagger_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .cfg_load_i(load),
    .cfg_enable_i(en), .cfg_stagger_i(stg), .cfg_nslot_i(nslot),
    .cfg_next_tbtt_i(nxt), .cfg_intval_i(ivl), .q_pending_i(pend),
    .miss_thresh_i(thr), .tsf_o(tsf), .swba_o(swba), .beacon_issue_o(issue),
    .slot_o(slot), .owner_o(owner), .miss_cnt_o(miss), .stuck_o(stuck),
    .run_o(run), .tsf_rst_o(trst), .tbtt_x8_o(tbtt8), .ivl_x8_o(ivl8)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prog(bit e, bit s, int n, longint t, longint iv, output longint seen);
    @(negedge clk);
    en = e; stg = s; nslot = 3'(n); nxt = 32'(t); ivl = 32'(iv);
    seen = longint'(tsf);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_alert(int max, output bit got, output longint tu);
    got = 0; tu = 0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (swba) begin
        got = 1; tu = longint'(tsf >> 10);
        s_slot = slot; s_owner = owner; s_miss = miss;
        s_issue = issue; s_stuck = stuck; s_tbtt = tbtt8;
        break;
      end
    end
    if (got) begin
      @(negedge clk);
      chk(!swba, "R4", "strobe one clock", longint'(swba), 0);
    end
  endtask

  function automatic longint slot_of(longint tu, longint p, longint n);
    return ((tu % p) * n) / p;
  endfunction

  function automatic longint owner_of(longint s, longint n);
    return (s + 1) % n;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    longint seen, tu, prev, exp_t, floor;
    bit got;
    int cnt, exp_miss;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    @(negedge clk);
    chk(tsf == 0 && !swba && !run && miss == 0 && !stuck && slot == 0, "R1",
        "reset state", longint'(tsf), 0);
    // R1: no tick holds, tick counts
    repeat (20) @(negedge clk);
    chk(tsf == 0, "R1", "hold without tick", longint'(tsf), 0);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    chk(tsf == 10, "R1", "count with tick", longint'(tsf), 10);

    // R2/R10: reset mode, period 3
    prog(1, 0, 0, 3, 3, seen);
    chk(trst == 1 && run == 1, "R2", "reset flag", longint'(trst), 1);
    chk(tsf < 4, "R2", "tsf zeroed", longint'(tsf), 1);
    chk(tbtt8 == 24, "R10", "target x8", longint'(tbtt8), 24);
    chk(ivl8 == 24, "R10", "interval x8", longint'(ivl8), 24);
    prev = 0;
    for (int k = 1; k <= 3; k++) begin
      wait_alert(4000, got, tu);
      chk(got && tu == 3 * k, "R2", "alert time unit", tu, 3 * k);
      if (k > 1) chk(tu - prev == 3, "R4", "alert spacing", tu - prev, 3);
      chk(s_tbtt == 8 * (3 * k + 3), "R10", "target x8 after alert",
          longint'(s_tbtt), 8 * (3 * k + 3));
      chk(s_slot == 0 && s_owner == 0, "R6", "unstaggered slot", longint'(s_slot), 0);
      prev = tu;
    end

    // R3: aligned start without timestamp reset
    prog(1, 0, 5, 1, 4, seen);
    chk(trst == 0 && tsf > seen, "R3", "timestamp kept", longint'(tsf), seen + 1);
    floor = (seen >> 10) + 2;
    exp_t = 1;
    while (exp_t < floor) exp_t += 4;
    wait_alert(8000, got, tu);
    chk(got && tu == exp_t, "R3", "first aligned alert", tu, exp_t);
    wait_alert(5000, got, tu);
    chk(got && tu == exp_t + 4, "R4", "aligned spacing", tu, exp_t + 4);

    // R5/R6: staggered, period 12, 3 slots -> interval 4
    prog(1, 1, 3, 4, 12, seen);
    chk(ivl8 == 32 && trst == 1, "R5", "staggered interval x8", longint'(ivl8), 32);
    for (int k = 1; k <= 3; k++) begin
      wait_alert(5000, got, tu);
      chk(got && tu == 4 * k, "R5", "slot alert time", tu, 4 * k);
      chk(s_slot == slot_of(tu, 12, 3), "R6", "current slot",
          longint'(s_slot), slot_of(tu, 12, 3));
      chk(s_owner == owner_of(slot_of(tu, 12, 3), 3), "R6", "next owner",
          longint'(s_owner), owner_of(slot_of(tu, 12, 3), 3));
    end

    // R5: N = 0 treated as 1
    prog(1, 1, 0, 2, 2, seen);
    chk(ivl8 == 16, "R5", "zero slot count", longint'(ivl8), 16);
    wait_alert(3000, got, tu);
    chk(got && tu == 2 && s_slot == 0 && s_owner == 0, "R6", "single slot",
        longint'(s_owner), 0);

    // R7/R8: misses, threshold 2
    thr = 4'd2;
    pend = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      wait_alert(3000, got, tu);
      chk(got && s_miss == k, "R7", "miss count", longint'(s_miss), k);
      chk(!s_issue, "R7", "no issue while busy", longint'(s_issue), 0);
      chk(s_stuck == (k >= 2), "R8", "stuck alarm", longint'(s_stuck), longint'(k >= 2));
    end
    repeat (50) @(negedge clk);
    chk(miss == 3, "R7", "hold between alerts", longint'(miss), 3);
    pend = 1'b0;
    wait_alert(3000, got, tu);
    chk(got && s_miss == 0 && s_issue, "R7", "clear on empty queue", longint'(s_miss), 0);
    chk(!s_stuck, "R8", "alarm drops", longint'(s_stuck), 0);

    // R9: masked interval of zero disables, no timestamp reset
    prog(1, 0, 1, 0, 32'h0001_0000, seen);
    chk(!run && !trst && tsf > seen, "R9", "masked zero disables", longint'(run), 0);
    cnt = 0;
    for (int i = 0; i < 2500; i++) begin @(negedge clk); if (swba) cnt++; end
    chk(cnt == 0, "R9", "no alerts disabled", cnt, 0);
    prog(1, 0, 1, 2, 32'h0001_0002, seen);
    chk(ivl8 == 16 && trst, "R9", "upper interval bits ignored", longint'(ivl8), 16);
    wait_alert(3000, got, tu);
    chk(got && tu == 2, "R9", "masked interval alert", tu, 2);

    // R11: load lands on the detection clock
    pend = 1'b1;
    prog(1, 0, 1, 2, 2, seen);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (tsf == 2048) break;
    end
    en = 1'b0; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    cnt = 0;
    for (int i = 0; i < 3000; i++) begin @(negedge clk); if (swba) cnt++; end
    chk(cnt == 0, "R11", "coincident alert suppressed", cnt, 0);
    chk(miss == 0 && !run, "R11", "miss untouched", longint'(miss), 0);
    pend = 1'b0;

    // random trials
    thr = 4'd3;
    exp_miss = 0;
    for (int t = 0; t < 5; t++) begin
      int p, nf, s, ne, ef;
      p  = 2 + int'($urandom % 4);
      s  = int'($urandom % 2);
      nf = 1 + int'($urandom % 3);
      if (s == 1 && nf > p) nf = p;
      ne = (s == 1) ? nf : 1;
      ef = p / ne;
      prog(1, s[0], nf, ef, p, seen);
      for (int k = 1; k <= 2; k++) begin
        pend = 1'($urandom % 2);
        wait_alert(6000, got, tu);
        exp_miss = pend ? ((exp_miss == 15) ? 15 : exp_miss + 1) : 0;
        chk(got && tu == ef * k, "R4", "random alert time", tu, ef * k);
        chk(s_slot == slot_of(tu, p, ne), "R6", "random slot",
            longint'(s_slot), slot_of(tu, p, ne));
        chk(s_owner == owner_of(slot_of(tu, p, ne), ne), "R6", "random owner",
            longint'(s_owner), owner_of(slot_of(tu, p, ne), ne));
        chk(s_miss == exp_miss && s_issue == !pend, "R7", "random miss",
            longint'(s_miss), exp_miss);
        chk(s_stuck == (exp_miss >= 3), "R8", "random alarm",
            longint'(s_stuck), longint'(exp_miss >= 3));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule